// File: doc/BRIEF.md
# Instruction Fetch and Branch Sequencer

This block is the front end of a small 8-bit processor with byte-wide opcodes and a 16-bit program counter. It reads one byte per clock from a byte-wide memory port at the program counter. An opcode lookup gives the instruction length, one, two or three bytes. For longer instructions it collects the operand bytes and assembles them into a 16-bit value, low byte first. Each finished instruction comes out as a one-cycle retire pulse carrying the opcode, the assembled operand and the length, for the execution logic that follows.

Jumps are resolved inside the block. An unconditional jump, or a conditional jump whose flag test passes, loads the program counter with the assembled address. The flag tests use the sign, zero, parity and carry inputs. The block also holds the halt state and the interrupt-enable flip-flop. A halt instruction stops all fetching. After that, only the trap input, an enabled maskable interrupt request or a reset restarts the processor. Interrupt vectoring, the ALU and memory contents belong to other blocks.

Top module: `fetch_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the program counter (`mem_addr`) becomes 0000h, `halted` and `int_en` become 0 and `instr_valid` becomes 0.
- R2: While not halted, `mem_rd` is 1. Each clock reads the byte at `mem_addr`, and the counter then advances by one, unless a taken jump loads it.
- R3: The length comes from the opcode. It is 3 for C3h, CDh, 22h, 2Ah, 32h, 3Ah and for patterns 11xxx010, 11xxx100 and 00xx0001. It is 2 for D3h, DBh and for patterns 00xxx110 and 11xxx110. Every other opcode is 1 byte long. `instr_len` reports the length with the retire pulse.
- R4: The first operand byte is the low half of `instr_operand` and the second is the high half. A two-byte instruction gives 00h as the high half, and a one-byte instruction gives 0000h.
- R5: A conditional jump has an opcode of the form 11ccc010. Bits cc[2:1] pick the flag: 0 zero, 1 carry, 2 parity, 3 sign. Bit cc[0] is 1 when the jump wants that flag set and 0 when it wants the flag clear. When the test passes, the counter is loaded with the operand and `jump_taken` pulses.
- R6: The unconditional jump C3h is always taken. A conditional jump that is not taken continues at the address just after its third byte.
- R7: Once the halt opcode 76h retires, `halted` is 1, `mem_rd` is 0, the counter holds, and nothing retires until the halt is left.
- R8: In halt, an active `trap_req` always clears `halted` at the next edge. An `irq_req` clears it only when `int_en` is 1, and has no effect otherwise.
- R9: Opcode F3h clears `int_en` and FBh sets it. The no-operation opcode 00h changes nothing except advancing the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Program counter, the address being read |
| mem_rd | output | 1 | Read strobe, high whenever fetching |
| mem_data | input | 8 | Byte at `mem_addr`, valid in the same cycle |
| flag_sign | input | 1 | Sign flag |
| flag_zero | input | 1 | Zero flag |
| flag_parity | input | 1 | Parity flag (1 = even) |
| flag_carry | input | 1 | Carry flag |
| irq_req | input | 1 | Maskable interrupt request |
| trap_req | input | 1 | Non-maskable trap request |
| instr_valid | output | 1 | One-cycle retire pulse |
| instr_opcode | output | 8 | Opcode of the retired instruction |
| instr_operand | output | 16 | Assembled operand of the retired instruction |
| instr_len | output | 2 | Length in bytes of the retired instruction |
| jump_taken | output | 1 | The retired instruction loaded the counter |
| halted | output | 1 | Halt state |
| int_en | output | 1 | Interrupt-enable flip-flop |

## Verification
A fixed directed prefix runs a no-operation, then enable-interrupt and halt, then disable-interrupt and halt, then an immediate load and a jump. This shows whether an interrupt request wakes the halt only when enabled and whether the trap wakes it regardless. After that, seeded random memory contents and random flag values drive thousands of instructions. That mix covers every length class, all eight jump conditions with both flag values, taken and untaken paths, and halts entered with the enable both set and clear. Each retire is compared with a bench model of the length table and the condition table. The model separates a wrong length from wrong operand byte order, and a wrong flag or flag sense from an untaken-path address that is off by one.

// File: rtl/fetch_seq_pkg.sv
// Package: shared opcode constants and types of the fetch sequencer.
// Assumes byte-wide opcodes; OP_W is fixed by the opcode encoding.
package fetch_seq_pkg;

    localparam int OP_W = 8;

    typedef logic [OP_W-1:0] opcode_t;

    // Opcodes the sequencer acts on directly
    localparam opcode_t OPC_NOP  = 8'h00;
    localparam opcode_t OPC_HALT = 8'h76;
    localparam opcode_t OPC_IDIS = 8'hF3;
    localparam opcode_t OPC_IENA = 8'hFB;
    localparam opcode_t OPC_JUMP = 8'hC3;

    // Fetch position within an instruction
    typedef enum logic [1:0] {
        FS_OPC = 2'd0,
        FS_LOB = 2'd1,
        FS_HIB = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/fetch_len_lut.sv
// Module: opcode length lookup and jump classification.
// Purely combinational. Unlisted opcodes are one byte long.
module fetch_len_lut
    import fetch_seq_pkg::*;
(
    input  opcode_t    opcode,
    output logic [1:0] len,
    output logic       is_jump,
    output logic       is_cond
);

    logic three_b;
    logic two_b;

    // Classify the opcode into three-byte and two-byte groups
    always_comb begin
        three_b = (opcode == OPC_JUMP) || (opcode == 8'hCD) ||
                  (opcode == 8'h22) || (opcode == 8'h2A) ||
                  (opcode == 8'h32) || (opcode == 8'h3A) ||
                  (opcode[7:6] == 2'b11 && opcode[2:0] == 3'b010) ||
                  (opcode[7:6] == 2'b11 && opcode[2:0] == 3'b100) ||
                  (opcode[7:6] == 2'b00 && opcode[3:0] == 4'b0001);
        two_b   = (opcode == 8'hD3) || (opcode == 8'hDB) ||
                  (opcode[7:6] == 2'b00 && opcode[2:0] == 3'b110) ||
                  (opcode[7:6] == 2'b11 && opcode[2:0] == 3'b110);
    end

    // Resolve the length and the jump class
    always_comb begin
        if (three_b)    len = 2'd3;
        else if (two_b) len = 2'd2;
        else            len = 2'd1;
        is_cond = (opcode[7:6] == 2'b11) && (opcode[2:0] == 3'b010);
        is_jump = is_cond || (opcode == OPC_JUMP);
    end

endmodule

// File: rtl/fetch_cond_eval.sv
// Module: conditional-jump test. The field cc selects one flag with
// cc[2:1] (0 zero, 1 carry, 2 parity, 3 sign); cc[0] is the wanted value.
module fetch_cond_eval (
    input  logic [2:0] cc,
    input  logic       flag_sign,
    input  logic       flag_zero,
    input  logic       flag_parity,
    input  logic       flag_carry,
    output logic       pass
);

    logic picked;

    // Pick the flag named by the condition field and compare with the sense bit
    always_comb begin
        unique case (cc[2:1])
            2'd0:    picked = flag_zero;
            2'd1:    picked = flag_carry;
            2'd2:    picked = flag_parity;
            default: picked = flag_sign;
        endcase
        pass = (picked == cc[0]);
    end

endmodule

// File: rtl/fetch_halt_ie.sv
// Module: halt state and interrupt-enable flip-flop.
// Assumes set_halt, clr_ie and set_ie arrive as single-cycle pulses
// and never while halted. The trap always ends halt; irq only when enabled.
module fetch_halt_ie (
    input  logic clk,
    input  logic rst_n,
    input  logic set_halt,
    input  logic clr_ie,
    input  logic set_ie,
    input  logic irq_req,
    input  logic trap_req,
    output logic halted,
    output logic int_en
);

    logic wake;

    // Decide whether a pending request ends the halt
    always_comb begin
        wake = halted && (trap_req || (irq_req && int_en));
    end

    // Track the halt state
    always_ff @(posedge clk) begin
        if (!rst_n)        halted <= 1'b0;
        else if (set_halt) halted <= 1'b1;
        else if (wake)     halted <= 1'b0;
    end

    // Track the interrupt-enable flip-flop
    always_ff @(posedge clk) begin
        if (!rst_n)      int_en <= 1'b0;
        else if (clr_ie) int_en <= 1'b0;
        else if (set_ie) int_en <= 1'b1;
    end

endmodule

// File: rtl/fetch_seq.sv
// Module: instruction fetch and branch sequencer (top).
// Reads one byte per cycle at the program counter, assembles operands
// low byte first, resolves jumps and drives a one-cycle retire pulse.
// Assumes mem_data is valid in the same cycle as mem_addr.
module fetch_seq
    import fetch_seq_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] RESET_PC = 16'h0000
)(
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [OP_W-1:0]   mem_data,
    input  logic              flag_sign,
    input  logic              flag_zero,
    input  logic              flag_parity,
    input  logic              flag_carry,
    input  logic              irq_req,
    input  logic              trap_req,
    output logic              instr_valid,
    output logic [OP_W-1:0]   instr_opcode,
    output logic [2*OP_W-1:0] instr_operand,
    output logic [1:0]        instr_len,
    output logic              jump_taken,
    output logic              halted,
    output logic              int_en
);

    localparam int                OPND_W = 2 * OP_W;
    localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PC_RST = ADDR_W'(RESET_PC);

    fetch_state_e        state_q;
    logic [ADDR_W-1:0]   pc_q;
    opcode_t             op_q;
    logic [OP_W-1:0]     lo_q;
    opcode_t             dec_op;
    logic [1:0]          dec_len;
    logic                dec_jump;
    logic                dec_cond;
    logic                cond_pass;
    logic [OPND_W-1:0]   full_opnd;
    logic                load_pc;
    logic                first_byte;
    logic                set_halt;
    logic                clr_ie;
    logic                set_ie;

    // Decode the byte being read in the opcode cycle, the held opcode later
    always_comb begin
        dec_op     = (state_q == FS_OPC) ? mem_data : op_q;
        first_byte = !halted && (state_q == FS_OPC);
        full_opnd  = {mem_data, lo_q};
        load_pc    = dec_jump && (!dec_cond || cond_pass);
        set_halt   = first_byte && (mem_data == OPC_HALT);
        clr_ie     = first_byte && (mem_data == OPC_IDIS);
        set_ie     = first_byte && (mem_data == OPC_IENA);
        mem_addr   = pc_q;
        mem_rd     = !halted;
    end

    fetch_len_lut u_len (
        .opcode  (dec_op),
        .len     (dec_len),
        .is_jump (dec_jump),
        .is_cond (dec_cond)
    );

    fetch_cond_eval u_cond (
        .cc          (op_q[5:3]),
        .flag_sign   (flag_sign),
        .flag_zero   (flag_zero),
        .flag_parity (flag_parity),
        .flag_carry  (flag_carry),
        .pass        (cond_pass)
    );

    fetch_halt_ie u_hie (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_halt (set_halt),
        .clr_ie   (clr_ie),
        .set_ie   (set_ie),
        .irq_req  (irq_req),
        .trap_req (trap_req),
        .halted   (halted),
        .int_en   (int_en)
    );

    // Step through the bytes of an instruction and retire it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= FS_OPC;
            pc_q          <= PC_RST;
            op_q          <= '0;
            lo_q          <= '0;
            instr_valid   <= 1'b0;
            instr_opcode  <= '0;
            instr_operand <= '0;
            instr_len     <= 2'd0;
            jump_taken    <= 1'b0;
        end else begin
            instr_valid <= 1'b0;
            jump_taken  <= 1'b0;
            if (!halted) begin
                unique case (state_q)
                    FS_OPC: begin
                        op_q <= mem_data;
                        pc_q <= pc_q + PC_ONE;
                        if (dec_len == 2'd1) begin
                            instr_valid   <= 1'b1;
                            instr_opcode  <= mem_data;
                            instr_operand <= '0;
                            instr_len     <= 2'd1;
                        end else begin
                            state_q <= FS_LOB;
                        end
                    end
                    FS_LOB: begin
                        lo_q <= mem_data;
                        pc_q <= pc_q + PC_ONE;
                        if (dec_len == 2'd2) begin
                            instr_valid   <= 1'b1;
                            instr_opcode  <= op_q;
                            instr_operand <= {{OP_W{1'b0}}, mem_data};
                            instr_len     <= 2'd2;
                            state_q       <= FS_OPC;
                        end else begin
                            state_q <= FS_HIB;
                        end
                    end
                    default: begin
                        instr_valid   <= 1'b1;
                        instr_opcode  <= op_q;
                        instr_operand <= full_opnd;
                        instr_len     <= 2'd3;
                        jump_taken    <= load_pc;
                        pc_q          <= load_pc ? ADDR_W'(full_opnd) : pc_q + PC_ONE;
                        state_q       <= FS_OPC;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/fetch_seq_chk.sv
// Module: property checker for fetch_seq, attached by bind.
// Observes ports only; holds no state of its own.
module fetch_seq_chk #(
    parameter int ADDR_W = 16
)(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              irq_req,
    input logic              trap_req,
    input logic              instr_valid,
    input logic [7:0]        instr_opcode,
    input logic [15:0]       instr_operand,
    input logic [1:0]        instr_len,
    input logic              jump_taken,
    input logic              halted,
    input logic              int_en
);

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (mem_addr == '0 && !halted && !int_en && !instr_valid));

    p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (jump_taken || mem_addr == $past(mem_addr) + ADDR_W'(1)));

    p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |-> instr_len != 2'd0);

    p_taken_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && jump_taken) |-> mem_addr == ADDR_W'(instr_operand));

    p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_rd);

    p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !trap_req && !irq_req) |=> (halted && $stable(mem_addr)));

    p_trap_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && trap_req) |=> !halted);

    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !trap_req && !int_en) |=> halted);

    p_nop_keeps_ie_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_opcode == 8'h00) |-> int_en == $past(int_en));

endmodule

bind fetch_seq fetch_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_addr      (mem_addr),
    .mem_rd        (mem_rd),
    .irq_req       (irq_req),
    .trap_req      (trap_req),
    .instr_valid   (instr_valid),
    .instr_opcode  (instr_opcode),
    .instr_operand (instr_operand),
    .instr_len     (instr_len),
    .jump_taken    (jump_taken),
    .halted        (halted),
    .int_en        (int_en)
);

// File: tb/fetch_seq_tb_top.sv
// Bench: directed prefix plus seeded random program and flags, each retire
// compared with a model built from the requirements.
module fetch_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_data;
    logic        flag_sign = 0, flag_zero = 0, flag_parity = 0, flag_carry = 0;
    logic        irq_req = 0, trap_req = 0;
    logic        instr_valid;
    logic [7:0]  instr_opcode;
    logic [15:0] instr_operand;
    logic [1:0]  instr_len;
    logic        jump_taken;
    logic        halted;
    logic        int_en;

    logic [7:0]  mem [0:1023];
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 0;

    always #5 clk = ~clk;

    assign mem_data = mem[mem_addr[9:0]];

    fetch_seq dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_data(mem_data), .flag_sign(flag_sign), .flag_zero(flag_zero),
        .flag_parity(flag_parity), .flag_carry(flag_carry),
        .irq_req(irq_req), .trap_req(trap_req), .instr_valid(instr_valid),
        .instr_opcode(instr_opcode), .instr_operand(instr_operand),
        .instr_len(instr_len), .jump_taken(jump_taken),
        .halted(halted), .int_en(int_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rd(input logic [15:0] a);
        return mem[a[9:0]];
    endfunction

    // Length table written from R3
    function automatic int ref_len(input logic [7:0] op);
        if (op inside {8'hC3, 8'hCD, 8'h22, 8'h2A, 8'h32, 8'h3A}) return 3;
        if ((op & 8'hC7) == 8'hC2 || (op & 8'hC7) == 8'hC4) return 3;
        if ((op & 8'hCF) == 8'h01) return 3;
        if (op inside {8'hD3, 8'hDB}) return 2;
        if ((op & 8'hC7) == 8'h06 || (op & 8'hC7) == 8'hC6) return 2;
        return 1;
    endfunction

    // Jump decision written from R5 and R6
    function automatic bit ref_take(input logic [7:0] op);
        case (op)
            8'hC3: return 1'b1;
            8'hC2: return !flag_zero;
            8'hCA: return flag_zero;
            8'hD2: return !flag_carry;
            8'hDA: return flag_carry;
            8'hE2: return !flag_parity;
            8'hEA: return flag_parity;
            8'hF2: return !flag_sign;
            8'hFA: return flag_sign;
            default: return 1'b0;
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] m_pc;
        bit          m_halted;
        bit          m_ie;
        bit          wake_pend;
        int          hcnt;
        int          retired;
        logic [7:0]  op;
        logic [15:0] opnd;
        logic [15:0] nxt;
        int          len;
        bit          tk;

        void'($urandom(32'd20240607));
        for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
        // Directed prefix: NOP, EI, HALT, DI, HALT, 2-byte load, JC 0100h, JMP 0010h
        mem[0] = 8'h00; mem[1] = 8'hFB; mem[2] = 8'h76; mem[3] = 8'hF3;
        mem[4] = 8'h76; mem[5] = 8'h3E; mem[6] = 8'h5A;
        mem[7] = 8'hDA; mem[8] = 8'h00; mem[9] = 8'h01;
        mem[10] = 8'hC3; mem[11] = 8'h10; mem[12] = 8'h00;
        mem[256] = 8'hC3; mem[257] = 8'h0D; mem[258] = 8'h00;
        mem[13] = 8'hCA; mem[14] = 8'h34; mem[15] = 8'h12;

        repeat (3) @(negedge clk);
        check(mem_addr == 16'h0000, "R1 reset pc", mem_addr, 0);
        check(!halted && !int_en, "R1 reset halt/ie", {halted, int_en}, 0);
        check(!instr_valid, "R1 reset valid", instr_valid, 0);
        rst_n = 1'b1;
        flag_carry = 1'b1;

        m_pc = 16'h0000; m_halted = 0; m_ie = 0; wake_pend = 0;
        hcnt = 0; retired = 0;

        for (int cyc = 0; cyc < 20000; cyc++) begin
            @(negedge clk);
            if (wake_pend) m_halted = 0;
            wake_pend = 0;

            if (instr_valid) begin
                retired++;
                check(!m_halted, "R7 retire while halted", 1, 0);
                op  = rd(m_pc);
                len = ref_len(op);
                opnd = (len == 3) ? {rd(m_pc + 16'd2), rd(m_pc + 16'd1)} :
                       (len == 2) ? {8'h00, rd(m_pc + 16'd1)} : 16'h0000;
                tk  = (len == 3) && ref_take(op);
                nxt = tk ? opnd : m_pc + 16'(len);
                check(instr_opcode == op, "R2 opcode", instr_opcode, op);
                check(int'(instr_len) == len, "R3 length", instr_len, len);
                check(instr_operand == opnd, "R4 operand", instr_operand, opnd);
                check(jump_taken == tk, tk ? "R5 taken" : "R6 not taken", jump_taken, tk);
                check(mem_addr == nxt, tk ? "R5 target" : "R6 next pc", mem_addr, nxt);
                m_pc = nxt;
                if (op == 8'hF3) m_ie = 0;
                if (op == 8'hFB) m_ie = 1;
                if (op == 8'h76) begin m_halted = 1; hcnt = 0; end
            end

            check(halted == m_halted, "R7/R8 halt state", halted, m_halted);
            check(int_en == m_ie, "R9 int enable", int_en, m_ie);
            check(mem_rd == !m_halted, "R2/R7 read strobe", mem_rd, !m_halted);
            if (m_halted)
                check(mem_addr == m_pc, "R7 pc holds", mem_addr, m_pc);

            flag_sign   = 1'($urandom);
            flag_zero   = 1'($urandom);
            flag_parity = 1'($urandom);
            flag_carry  = 1'($urandom);
            if (m_halted) begin
                hcnt++;
                irq_req  = (hcnt == 2);
                trap_req = (hcnt == 4);
                wake_pend = trap_req || (irq_req && m_ie);
            end else begin
                irq_req  = ($urandom % 4) == 0;
                trap_req = ($urandom % 8) == 0;
            end
        end
        check(retired > 1000, "R2 progress", retired, 1000);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule